// File: doc/BRIEF.md
# Serial NOR Flash Burst Reader

This block pulls a contiguous run of bytes out of a standard serial NOR flash and hands them to the rest of the chip as a valid/ready stream. A one-cycle start strobe supplies a 24-bit byte address, a length and a packing choice. The block pulls the select line low and sends the plain read opcode and the three address bytes. It then clocks one all-zero byte per data byte wanted, and releases select once the final byte has been clocked.

In byte mode every stream beat carries one received byte in its low eight bits, and the length counts bytes. In packed mode four consecutive received bytes form one 32-bit beat, with the earliest byte in the most significant position, and the length counts beats, so four times as many bytes cross the wire. The serial clock is mode 0: it idles low, the flash's output is sampled on the rising edge, and outgoing bits change on the falling edge. Its half period is a parameter measured in system clocks. When the stream consumer stalls, the serial transfer pauses at a byte boundary rather than dropping data.

Top module: `flash_burst_reader`

## Requirements
- R1: The first byte sent after select falls is the read opcode 0x03. Every byte goes out most significant bit first, with the serial clock idling low, the flash output sampled on its rising edge and outgoing bits changing on its falling edge.
- R2: Three address bytes follow the opcode: bits 23..16 first, then 15..8, then 7..0.
- R3: During the data phase every byte transmitted is 0x00. The number of data bytes equals the length in byte mode and four times the length in packed mode.
- R4: In byte mode each stream beat holds the received byte in bits 7..0, with bits 31..8 zero. Beats come out in address order.
- R5: In packed mode, byte k (k = 0..3) of each group of four lands in bits 31-8k down to 24-8k of its beat. Beats come out in address order.
- R6: Select stays low without a break from before the opcode until after the last data byte's final clock. No serial clock edge occurs while select is high.
- R7: While a beat is valid and not accepted, its data stays stable. No serial clock edge occurs while a beat is pending, so the next byte transfer does not start until the pending beat is taken.
- R8: `done_o` is a single-cycle pulse. It is raised only after select has been released and the last beat has been accepted. `busy_o` is high from the cycle after an accepted start until that pulse.
- R9: A start strobe that arrives while `busy_o` is high is ignored. The running burst keeps its address, length and mode, and no second burst follows.
- R10: A start with a length of zero never lowers select. It raises `done_o` in the cycle after the strobe.
- R11: After reset, select is high, the serial clock is low, and `out_valid_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a burst |
| addr_i | input | 24 | Flash byte address of the first byte |
| len_i | input | LEN_W (12) | Burst length, in bytes or in 32-bit beats |
| pack_i | input | 1 | 1 selects packed 32-bit beats, 0 selects byte beats |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| out_data_o | output | 32 | Stream beat data |
| out_valid_o | output | 1 | Stream beat valid |
| out_ready_i | input | 1 | Stream consumer ready |
| spi_sck_o | output | 1 | Serial clock to the flash |
| spi_cs_n_o | output | 1 | Active-low flash select |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
Two events can share a clock cycle: the consumer accepting the pending beat, and the engine deciding to launch the next byte transfer. The launch is allowed in exactly that cycle, and the newly received byte then has to find an empty output slot. To provoke this, the bench raises ready only on every fifth cycle during packed and byte bursts, so acceptances repeatedly fall on launch opportunities. It then judges the result at the pins: no serial clock edge while a beat is pending, each pending beat held unchanged, and the collected beat sequence equal to the one predicted from the flash model's contents.

// File: rtl/flash_rd_pkg.sv
`timescale 1ns/1ps
package flash_rd_pkg;

  localparam logic [7:0] READ_OPCODE = 8'h03;
  localparam logic [7:0] FILL_BYTE   = 8'h00;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_HDR,
    SEQ_DATA,
    SEQ_DRAIN
  } seq_state_t;

  // Number of bytes on the wire for a given length and mode.
  function automatic logic [31:0] burst_bytes(input logic [31:0] len, input logic pack);
    return pack ? (len << 2) : len;
  endfunction

  // Header byte idx of a read: opcode, then address high to low.
  function automatic logic [7:0] header_byte(input logic [23:0] addr, input logic [1:0] idx);
    case (idx)
      2'd0:    return READ_OPCODE;
      2'd1:    return addr[23:16];
      2'd2:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction

  // Merge byte k of a group into a word, earliest byte most significant.
  function automatic logic [31:0] place_byte(input logic [31:0] acc, input logic [7:0] b,
                                             input logic [1:0] k);
    logic [4:0]  sh;
    logic [31:0] base;
    sh   = 5'd24 - {k, 3'b000};
    base = (k == 2'd0) ? 32'h0 : acc;
    return base | ({24'h0, b} << sh);
  endfunction

endpackage

// File: rtl/flash_spi_shifter.sv
`timescale 1ns/1ps
module flash_spi_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       active_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             active_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       fall_cnt_q;
  logic             sck_q;
  logic [7:0]       tx_q;
  logic [7:0]       rx_q;
  logic             done_q;

  // Named events for the checks below.
  logic tick_w, rise_w, fall_w;
  assign tick_w = active_q && (div_q == DIV_LAST);
  assign rise_w = tick_w && !sck_q;
  assign fall_w = tick_w && sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      div_q      <= '0;
      fall_cnt_q <= '0;
      sck_q      <= 1'b0;
      tx_q       <= '0;
      rx_q       <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q   <= 1'b1;
        tx_q       <= tx_i;
        div_q      <= '0;
        fall_cnt_q <= '0;
        sck_q      <= 1'b0;
      end else if (active_q) begin
        if (tick_w) div_q <= '0;
        else        div_q <= div_q + 1'b1;
        if (rise_w) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso_i};
        end
        if (fall_w) begin
          sck_q      <= 1'b0;
          tx_q       <= {tx_q[6:0], 1'b0};
          fall_cnt_q <= fall_cnt_q + 1'b1;
          if (fall_cnt_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = tx_q[7];
  assign rx_o     = rx_q;
  assign done_o   = done_q;
  assign active_o = active_q;

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !active_q); // R3
  AST_DONE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !sck_q); // R1
endmodule

// File: rtl/flash_word_packer.sv
`timescale 1ns/1ps
module flash_word_packer
  import flash_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        emit_i,
  input  logic [7:0]  byte_i,
  input  logic        pack_i,
  input  logic        ready_i,
  output logic [31:0] data_o,
  output logic        valid_o,
  output logic        slot_free_o
);
  logic [1:0]  grp_q;
  logic [31:0] acc_q;
  logic [31:0] data_q;
  logic        valid_q;
  logic [31:0] merged_w;
  logic        take_w;

  assign merged_w = place_byte(acc_q, byte_i, grp_q);
  assign take_w   = valid_q && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q   <= '0;
      acc_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (take_w) valid_q <= 1'b0;
      if (clear_i) begin
        grp_q <= '0;
      end else if (emit_i) begin
        if (pack_i) begin
          acc_q <= merged_w;
          grp_q <= grp_q + 1'b1;
          if (grp_q == 2'd3) begin
            data_q  <= merged_w;
            valid_q <= 1'b1;
          end
        end else begin
          data_q  <= {24'h0, byte_i};
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign slot_free_o = !valid_q || ready_i;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    emit_i |-> !valid_q); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q))); // R7
endmodule

// File: rtl/flash_burst_seq.sv
`timescale 1ns/1ps
module flash_burst_seq
  import flash_rd_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [23:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pack_i,
  input  logic             byte_done_i,
  input  logic             slot_free_i,
  input  logic             out_valid_i,
  output logic             go_o,
  output logic [7:0]       tx_o,
  output logic             cs_n_o,
  output logic             emit_o,
  output logic             clear_o,
  output logic             pack_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CNT_W = LEN_W + 2;

  seq_state_t       state_q;
  logic [23:0]      addr_q;
  logic             pack_q;
  logic [CNT_W-1:0] left_q;
  logic [1:0]       hdr_idx_q;
  logic             inflight_q;
  logic             go_q;
  logic [7:0]       tx_q;
  logic             cs_n_q;
  logic             done_q;
  logic [31:0]      total_w;
  logic             accept_w;

  assign total_w  = burst_bytes(32'(len_i), pack_i);
  assign accept_w = (state_q == SEQ_IDLE) && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      addr_q     <= '0;
      pack_q     <= 1'b0;
      left_q     <= '0;
      hdr_idx_q  <= '0;
      inflight_q <= 1'b0;
      go_q       <= 1'b0;
      tx_q       <= '0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (accept_w) begin
            if (len_i == '0) begin
              done_q <= 1'b1;
            end else begin
              addr_q     <= addr_i;
              pack_q     <= pack_i;
              left_q     <= total_w[CNT_W-1:0];
              hdr_idx_q  <= '0;
              inflight_q <= 1'b0;
              cs_n_q     <= 1'b0;
              state_q    <= SEQ_HDR;
            end
          end
        end
        SEQ_HDR: begin
          if (!inflight_q) begin
            go_q       <= 1'b1;
            tx_q       <= header_byte(addr_q, hdr_idx_q);
            inflight_q <= 1'b1;
          end else if (byte_done_i) begin
            inflight_q <= 1'b0;
            hdr_idx_q  <= hdr_idx_q + 1'b1;
            if (hdr_idx_q == 2'd3) state_q <= SEQ_DATA;
          end
        end
        SEQ_DATA: begin
          if (!inflight_q) begin
            if (slot_free_i) begin
              go_q       <= 1'b1;
              tx_q       <= FILL_BYTE;
              inflight_q <= 1'b1;
            end
          end else if (byte_done_i) begin
            inflight_q <= 1'b0;
            left_q     <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) begin
              cs_n_q  <= 1'b1;
              state_q <= SEQ_DRAIN;
            end
          end
        end
        default: begin
          if (!out_valid_i) begin
            done_q  <= 1'b1;
            state_q <= SEQ_IDLE;
          end
        end
      endcase
    end
  end

  assign go_o    = go_q;
  assign tx_o    = tx_q;
  assign cs_n_o  = cs_n_q;
  assign emit_o  = (state_q == SEQ_DATA) && inflight_q && byte_done_i;
  assign clear_o = (state_q == SEQ_IDLE);
  assign pack_o  = pack_q;
  assign busy_o  = (state_q != SEQ_IDLE);
  assign done_o  = done_q;

  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cs_n_q); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(addr_q) && $stable(pack_q))); // R9
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !out_valid_i); // R8
endmodule

// File: rtl/flash_burst_reader.sv
`timescale 1ns/1ps
module flash_burst_reader
  import flash_rd_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [23:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [31:0]      out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             spi_sck_o,
  output logic             spi_cs_n_o,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i
);
  logic       go_w, byte_done_w, shift_active_w;
  logic [7:0] tx_w, rx_w;
  logic       emit_w, clear_w, pack_w, slot_free_w, valid_w;
  logic       cs_n_w, sck_w;

  flash_burst_seq #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .len_i       (len_i),
    .pack_i      (pack_i),
    .byte_done_i (byte_done_w),
    .slot_free_i (slot_free_w),
    .out_valid_i (valid_w),
    .go_o        (go_w),
    .tx_o        (tx_w),
    .cs_n_o      (cs_n_w),
    .emit_o      (emit_w),
    .clear_o     (clear_w),
    .pack_o      (pack_w),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  flash_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (go_w),
    .tx_i     (tx_w),
    .miso_i   (spi_miso_i),
    .sck_o    (sck_w),
    .mosi_o   (spi_mosi_o),
    .rx_o     (rx_w),
    .done_o   (byte_done_w),
    .active_o (shift_active_w)
  );

  flash_word_packer u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_w),
    .emit_i      (emit_w),
    .byte_i      (rx_w),
    .pack_i      (pack_w),
    .ready_i     (out_ready_i),
    .data_o      (out_data_o),
    .valid_o     (valid_w),
    .slot_free_o (slot_free_w)
  );

  assign out_valid_o = valid_w;
  assign spi_cs_n_o  = cs_n_w;
  assign spi_sck_o   = sck_w;

  AST_XFER_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    shift_active_w |-> !cs_n_w); // R6
  AST_SCK_LOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_w |-> !sck_w); // R6
  AST_NO_CLOCK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_w && !out_ready_i) |=> !go_w); // R7
endmodule

// File: tb/flash_burst_reader_tb.sv
`timescale 1ns/1ps
module flash_burst_reader_tb;
  localparam int LEN_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [23:0]      addr_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic             pack_i = 1'b0;
  logic             busy_o, done_o, out_valid_o;
  logic [31:0]      out_data_o;
  logic             out_ready_i = 1'b1;
  logic             spi_sck_o, spi_cs_n_o, spi_mosi_o;
  logic             spi_miso_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_burst_reader #(.LEN_W(LEN_W), .HALF_DIV(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .pack_i(pack_i), .busy_o(busy_o), .done_o(done_o), .out_data_o(out_data_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .spi_sck_o(spi_sck_o),
    .spi_cs_n_o(spi_cs_n_o), .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i)
  );

  // Flash contents model.
  function automatic logic [7:0] fmem(input logic [23:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction

  // Flash slave model.
  int          bitcnt = 0;
  logic [31:0] hdr_sh = '0;
  logic [31:0] last_hdr = '0;
  int          last_bits = 0;
  int          cs_falls = 0;
  int          mosi_err = 0;
  int          stall_err = 0;

  always @(negedge spi_cs_n_o) begin
    bitcnt = 0;
    hdr_sh = '0;
    cs_falls++;
  end
  always @(posedge spi_cs_n_o) begin
    last_hdr  = hdr_sh;
    last_bits = bitcnt;
  end
  always @(posedge spi_sck_o) begin
    if (spi_cs_n_o) stall_err++;
    else begin
      if (bitcnt < 32) hdr_sh = {hdr_sh[30:0], spi_mosi_o};
      else if (spi_mosi_o !== 1'b0) mosi_err++;
      if (out_valid_o) stall_err++;
      bitcnt++;
    end
  end
  always @(negedge spi_sck_o) begin
    if (!spi_cs_n_o && bitcnt >= 32) begin
      logic [7:0] b;
      b = fmem(hdr_sh[23:0] + 24'((bitcnt - 32) / 8));
      spi_miso_i = b[7 - ((bitcnt - 32) % 8)];
    end
  end

  // Consumer: ready pattern, capture, hold check, done count.
  int          rmode = 0;
  int          cyc = 0;
  logic [31:0] cap [0:63];
  int          ncap = 0;
  int          done_cnt = 0;
  int          hold_err = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  always @(negedge clk) begin
    cyc++;
    if (prev_stall && (!out_valid_o || out_data_o !== prev_data)) hold_err++;
    out_ready_i = (rmode == 0) ? 1'b1 : ((cyc % 5) == 0);
    if (out_valid_o && out_ready_i && ncap < 64) begin
      cap[ncap] = out_data_o;
      ncap++;
    end
    prev_stall = out_valid_o && !out_ready_i;
    prev_data  = out_data_o;
    if (done_o) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(spi_cs_n_o === 1'b1, "R11 select high", 32'(spi_cs_n_o), 1);
    chk(spi_sck_o === 1'b0, "R11 sck low", 32'(spi_sck_o), 0);
    chk(out_valid_o === 1'b0, "R11 valid low", 32'(out_valid_o), 0);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R11 busy/done low",
        {30'h0, busy_o, done_o}, 0);
  endtask

  // One burst with full checking of header, data count, beats and done.
  task automatic run_burst(input logic [23:0] a, input int n, input bit pk,
                           input int rm, input bit poke);
    int  d0, f0, nb, c;
    bit  got, cs_at;
    logic [31:0] exp;
    rmode = rm; ncap = 0; mosi_err = 0; stall_err = 0; hold_err = 0;
    d0 = done_cnt; f0 = cs_falls;
    @(negedge clk);
    start_i = 1'b1; addr_i = a; len_i = LEN_W'(n); pack_i = pk;
    @(negedge clk);
    start_i = 1'b0; addr_i = 24'h0; len_i = '0; pack_i = 1'b0;
    chk(busy_o === 1'b1, "R8 busy after start", 32'(busy_o), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1; addr_i = 24'h777777; len_i = LEN_W'(9); pack_i = !pk;
      @(negedge clk);
      start_i = 1'b0; addr_i = 24'h0; len_i = '0; pack_i = 1'b0;
    end
    got = 0; cs_at = 0;
    for (c = 0; c < 40000 && !got; c++) begin
      @(negedge clk);
      if (done_o) begin got = 1; cs_at = spi_cs_n_o; end
    end
    chk(got, "R8 done seen", 32'(got), 1);
    chk(cs_at === 1'b1, "R8 select released at done", 32'(cs_at), 1);
    repeat (60) @(negedge clk);
    chk(done_cnt == d0 + 1, "R8 R9 single done", 32'(done_cnt - d0), 1);
    chk(cs_falls == f0 + 1, "R6 R9 one select window", 32'(cs_falls - f0), 1);
    chk(last_hdr[31:24] == 8'h03, "R1 opcode", 32'(last_hdr[31:24]), 32'h03);
    chk(last_hdr[23:0] == a, "R2 address", 32'(last_hdr[23:0]), 32'(a));
    nb = pk ? 4 * n : n;
    chk(last_bits == 32 + 8 * nb, "R3 R6 bit count", 32'(last_bits), 32'(32 + 8 * nb));
    chk(mosi_err == 0, "R3 zero fill", 32'(mosi_err), 0);
    chk(stall_err == 0, "R7 R6 no clock while pending", 32'(stall_err), 0);
    chk(hold_err == 0, "R7 beat held", 32'(hold_err), 0);
    chk(ncap == n, "R4 R5 beat count", 32'(ncap), 32'(n));
    for (int i = 0; i < n && i < ncap; i++) begin
      if (pk)
        exp = {fmem(a + 24'(4*i)), fmem(a + 24'(4*i+1)),
               fmem(a + 24'(4*i+2)), fmem(a + 24'(4*i+3))};
      else
        exp = {24'h0, fmem(a + 24'(i))};
      chk(cap[i] === exp, pk ? "R5 packed beat" : "R4 byte beat", cap[i], exp);
    end
  endtask

  task automatic t_zero_len();
    int f0;
    f0 = cs_falls;
    @(negedge clk);
    start_i = 1'b1; addr_i = 24'h00_1000; len_i = '0; pack_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o === 1'b1, "R10 done next cycle", 32'(done_o), 1);
    repeat (20) @(negedge clk);
    chk(cs_falls == f0, "R10 select untouched", 32'(cs_falls - f0), 0);
    chk(busy_o === 1'b0, "R10 not busy", 32'(busy_o), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_burst(24'h012345, 5, 1'b0, 0, 1'b0);
    run_burst(24'hABCDEF, 3, 1'b1, 0, 1'b0);
    run_burst(24'h00FFFE, 4, 1'b1, 1, 1'b0);
    run_burst(24'h3C0001, 6, 1'b0, 1, 1'b0);
    run_burst(24'h400100, 2, 1'b1, 0, 1'b1);
    run_burst(24'hFFFFFF, 1, 1'b0, 0, 1'b0);
    t_zero_len();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule